// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block keeps the interrupt state of one DMA channel. Five one-cycle event pulses come from the transfer engine: descriptor done, address misalignment, bus error, whole-transfer done and block done. Each pulse latches a sticky status flag. A per-source enable mask selects which flags count towards a channel summary flag. A registered interrupt line follows that summary.

Software uses a small register port with one address shared by reads and writes. Writes take effect at the clock edge, and read data is combinational. Mask bits are set through one address and cleared through another; either address reads the mask back. The status address reads the five flags with the summary above them. A write of ones to the status address clears the flags at those positions. The summary bit cannot be written and falls only once the flags behind it are gone.

Top module: `irq_stat_unit`

## Requirements
- R1: After reset the mask, all status flags, the summary bit and irqOut read as zero.
- R2: A pulse on evtPulse[i] sets status bit i on the next clock edge, whether or not mask bit i is set. The bit positions are: 0 descriptor done, 1 address error, 2 bus error, 3 transfer done, 4 block done.
- R3: A write to address 0 sets every mask bit whose data bit is one and leaves the others unchanged. Reads at address 0 or 1 return the mask in bits 4:0 and zero above.
- R4: A write to address 1 clears every mask bit whose data bit is one and leaves the others unchanged.
- R5: A write to address 2 clears every status flag whose data bit is one. Flags at positions written with zero keep their value.
- R6: If an event pulse and a clearing write hit the same flag in the same cycle, the flag is set after the edge.
- R7: A read of address 2 returns the flags in bits 4:0 and the summary in bit 5. The summary is the OR of the flags whose mask bit is one.
- R8: Writing bit 5 of address 2 has no effect. The summary falls only when its contributing flags are cleared or masked off.
- R9: irqOut is driven from a register and equals the summary bit in every cycle after reset.
- R10: A write to address 3 changes nothing, and reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| evtPulse | input | 5 | One-cycle event pulses, one bit per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for reads and writes |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| irqOut | output | 1 | Channel interrupt line |

## Verification
An event pulse and a software clear can reach the same flag in one cycle. A flag can also be cleared while another unmasked flag arrives. The vector table drives both cases in single cycles. In one vector the pulse and the clear target the same bit, and the flag must stay set. In another, a write-all-ones clear meets a pulse on one bit, and only that bit may survive. Each case is judged by reading status and mask through the register port right after the edge and comparing irqOut with the expected summary.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned N_SRC = 5;
  localparam int unsigned SUM_BIT = N_SRC;

  localparam logic [1:0] ADDR_MASK_SET = 2'd0;
  localparam logic [1:0] ADDR_MASK_CLR = 2'd1;
  localparam logic [1:0] ADDR_STATUS   = 2'd2;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic [N_SRC-1:0] maskSet;
    logic [N_SRC-1:0] maskClr;
    logic [N_SRC-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output strobe_t           strobe,
  output rd_sel_e           rdSel
);
  logic [N_SRC-1:0] wrBits;
  logic unusedHiBits;

  assign wrBits = regWrData[N_SRC-1:0];
  assign unusedHiBits = ^regWrData[DATA_W-1:N_SRC];

  always_comb begin
    strobe = '0;
    rdSel = RD_NONE;
    unique case (regAddr)
      ADDR_MASK_SET: begin
        rdSel = RD_MASK;
        if (regWrEn) strobe.maskSet = wrBits;
      end
      ADDR_MASK_CLR: begin
        rdSel = RD_MASK;
        if (regWrEn) strobe.maskClr = wrBits;
      end
      ADDR_STATUS: begin
        rdSel = RD_STATUS;
        if (regWrEn) strobe.flagClr = wrBits;
      end
      default: ;
    endcase
  end

  // At most one kind of strobe per cycle, and none without a write (R10)
  assert_one_strobe_kind_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({|strobe.maskSet, |strobe.maskClr, |strobe.flagClr}) <= 1);
  assert_no_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> (strobe == '0));
endmodule

// File: rtl/irq_stat_datapath.sv
module irq_stat_datapath
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  evtPulse,
  input  strobe_t           strobe,
  input  rd_sel_e           rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [N_SRC-1:0] maskQ, maskD;
  logic [N_SRC-1:0] flagQ, flagD;
  logic summary;

  assign maskD = (maskQ | strobe.maskSet) & ~strobe.maskClr;

  // One sticky cell per source; the event wins over a same-cycle clear
  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_flag
    assign flagD[gi] = evtPulse[gi] | (flagQ[gi] & ~strobe.flagClr[gi]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      flagQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      maskQ  <= maskD;
      flagQ  <= flagD;
      irqOut <= |(flagD & maskD);
    end
  end

  assign summary = |(flagQ & maskQ);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_MASK:   rdData[N_SRC-1:0] = maskQ;
      RD_STATUS: begin
        rdData[N_SRC-1:0] = flagQ;
        rdData[SUM_BIT]   = summary;
      end
      default: ;
    endcase
  end

  assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    |evtPulse |=> ((flagQ & $past(evtPulse)) == $past(evtPulse)));
  assert_clear_drops_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    |(strobe.flagClr & ~evtPulse) |=> ((flagQ & $past(strobe.flagClr & ~evtPulse)) == '0));
  assert_unwritten_flag_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagQ & $past(flagQ & ~strobe.flagClr)) == $past(flagQ & ~strobe.flagClr)));
  assert_mask_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskSet == '0 && strobe.maskClr == '0) |=> $stable(maskQ));
  assert_summary_fall_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(summary) |-> $past((strobe.flagClr != '0) || (strobe.maskClr != '0)));
  assert_irq_tracks_summary_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == summary));
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        evtPulse,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  strobe_t strobe;
  rd_sel_e rdSel;

  irq_stat_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .rdSel(rdSel)
  );

  irq_stat_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .strobe(strobe),
    .rdSel(rdSel), .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_stat_unit_bench.sv
module irq_stat_unit_bench;
  localparam int PERIOD = 10;
  localparam int NVEC = 14;
  // {wrEn, addr, wdata, evt, expStatus, expMask}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 8'h05, 5'b00000, 8'h00, 8'h05},
    {1'b0, 2'd0, 8'h00, 5'b00010, 8'h02, 8'h05},
    {1'b0, 2'd0, 8'h00, 5'b00100, 8'h26, 8'h05},
    {1'b1, 2'd2, 8'h20, 5'b00000, 8'h26, 8'h05},
    {1'b1, 2'd2, 8'h04, 5'b00100, 8'h26, 8'h05},
    {1'b1, 2'd2, 8'h04, 5'b00000, 8'h02, 8'h05},
    {1'b1, 2'd0, 8'h02, 5'b00000, 8'h22, 8'h07},
    {1'b1, 2'd1, 8'h02, 5'b00000, 8'h02, 8'h05},
    {1'b0, 2'd0, 8'h00, 5'b11001, 8'h3B, 8'h05},
    {1'b1, 2'd3, 8'hFF, 5'b00000, 8'h3B, 8'h05},
    {1'b1, 2'd2, 8'h1F, 5'b10000, 8'h10, 8'h05},
    {1'b1, 2'd0, 8'h10, 5'b00000, 8'h30, 8'h15},
    {1'b1, 2'd2, 8'h00, 5'b00000, 8'h30, 8'h15},
    {1'b1, 2'd2, 8'h10, 5'b00000, 8'h00, 8'h15}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] evtPulse = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqOut;
  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_stat_unit u_irq_stat_unit (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic string reqOf(int idx);
    case (idx)
      0: return "R3";  1: return "R2";  2: return "R7";  3: return "R8";
      4: return "R6";  5: return "R5";  6: return "R3";  7: return "R4";
      8: return "R2";  9: return "R10"; 10: return "R6"; 11: return "R7";
      12: return "R5"; default: return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readAll(string req, logic [7:0] expStatus, logic [7:0] expMask);
    regAddr = 2'd2; #1;
    check(req, "status", regRdData, expStatus);
    regAddr = 2'd0; #1;
    check(req, "mask", regRdData, expMask);
    check("R9", "irqOut", {7'd0, irqOut}, {7'd0, expStatus[5]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    readAll("R1", 8'h00, 8'h00);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      {regWrEn, regAddr, regWrData, evtPulse} = VEC[i][31:16];
      @(posedge clk); #1;
      regWrEn = 1'b0; evtPulse = '0;
      readAll(reqOf(i), VEC[i][15:8], VEC[i][7:0]);
    end
    // R10: address 3 reads zero
    regAddr = 2'd3; #1;
    check("R10", "addr3 read", regRdData, 8'h00);
    // R1: reset in the middle of a run clears everything
    evtPulse = 5'b11111;
    @(posedge clk); #1;
    evtPulse = '0;
    readAll("R7", 8'h3F, 8'h15);
    rstN = 1'b0;
    @(posedge clk); #1;
    readAll("R1", 8'h00, 8'h00);
    rstN = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule